// File: doc/BRIEF.md
# Interrupt Posting Sequencer

This block sits on the I/O side of the system. It raises an interrupt cell for a channel. A request names the channel and the target cell. The sequencer first checks that the cell belongs to this unit's group. It then does an atomic read-and-clear of the multiplex word that belongs to that cell. It ORs the channel's bit into the value it read and writes the word back. Only after the write is accepted does it ask the cell controller to set the cell.

The multiplex word address is physical and is never translated. It is the 13-bit configured base followed by the 5-bit cell number, so the 32 words lie on a 32-word boundary. The unit holds one request at a time. `busy` stays high from acceptance until the cell-set handshake completes. A request aimed at a cell outside the unit's group is refused with a one-cycle `reject` pulse and causes no memory traffic.

The controller has six states:
- ST_IDLE: waits for a request. Goes to ST_RC_ISSUE when the check passes, otherwise to ST_REJECT.
- ST_REJECT: returns to ST_IDLE after one cycle.
- ST_RC_ISSUE: presents the read-and-clear. Goes to ST_RC_WAIT when `mem_ready` is high.
- ST_RC_WAIT: waits for `mem_rvalid`, then goes to ST_WR_ISSUE.
- ST_WR_ISSUE: presents the write. Goes to ST_CELL_REQ when `mem_ready` is high.
- ST_CELL_REQ: raises the cell-set request. Goes to ST_IDLE when `cell_set_ack` is high.

Top module: `irq_post_seq`

## Requirements
- R1: After reset, `req_ready` is 1 and `busy`, `reject`, `mem_req` and `cell_set_req` are all 0.
- R2: Every memory access of a posting uses `mem_addr` = {`mpx_base`, cell}, with `mpx_base` in bits 17:5 and the cell number in bits 4:0.
- R3: The first access of a posting is a read-and-clear, with `mem_rdclr` = 1. It is presented in the cycle after the request is accepted.
- R4: The written word equals the value returned by the read-and-clear, with the channel's bit set. All other bits keep the value that was read, including bits 35:32.
- R5: The write, with `mem_rdclr` = 0, is accepted before `cell_set_req` rises. `cell_set_num` equals the requested cell.
- R6: While `mem_ready` is 0, a pending memory request stays asserted with the same address and operation.
- R7: `busy` is 1 and `req_ready` is 0 from acceptance until `cell_set_ack` is seen. Requests offered meanwhile are ignored.
- R8: A cell whose bits 1:0 differ from `unit_id`, or a cell below 4, is refused. The refusal is a `reject` pulse of exactly one cycle, with no memory request and no cell-set request.
- R9: Only bits 4:0 of the channel number select the bit in the word. Higher channel bits have no effect.
- R10: `cell_set_req` and `cell_set_num` hold until `cell_set_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| unit_id | input | 2 | This unit's number; selects its cell group |
| mpx_base | input | 13 | Base of the multiplex word block |
| req_valid | input | 1 | Posting request offered |
| req_ready | output | 1 | Request taken when high together with req_valid |
| req_chan | input | 6 | Channel number |
| req_cell | input | 5 | Target cell |
| mem_req | output | 1 | Memory request |
| mem_rdclr | output | 1 | 1 = atomic read-and-clear, 0 = write |
| mem_addr | output | 18 | Physical word address |
| mem_wdata | output | 36 | Write data |
| mem_ready | input | 1 | Memory request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 36 | Read data |
| cell_set_req | output | 1 | Request to set a cell |
| cell_set_num | output | 5 | Cell to set |
| cell_set_ack | input | 1 | Cell set acknowledged |
| busy | output | 1 | A request is in progress |
| reject | output | 1 | One-cycle pulse for a refused request |

## Verification
The assertions assume the following about the block's inputs:
- `mpx_base` and `unit_id` stay constant while a posting is in flight.
- `mem_rvalid` arrives only after a read-and-clear has been accepted.
- `cell_set_ack` is given only while `cell_set_req` is high.

The bench drives all three handshakes from the same tasks that run each scenario, so these rules hold by construction. It changes `unit_id` only while the block is idle, and it pulses `mem_rvalid` once per read.

// File: rtl/irq_post_pkg.sv
package irq_post_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REJECT,
        ST_RC_ISSUE,
        ST_RC_WAIT,
        ST_WR_ISSUE,
        ST_CELL_REQ
    } post_state_e;
endpackage

// File: rtl/irq_req_check.sv
module irq_req_check #(
    parameter int CELL_W   = 5,
    parameter int UNIT_W   = 2,
    parameter int BASE_W   = 13,
    parameter int MIN_CELL = 4,
    localparam int ADDR_W  = BASE_W + CELL_W
) (
    input  logic [CELL_W-1:0] in_cell,
    input  logic [UNIT_W-1:0] unit_id,
    input  logic [BASE_W-1:0] base,
    input  logic [CELL_W-1:0] held_cell,
    output logic              cell_ok,
    output logic [ADDR_W-1:0] word_addr
);
    always_comb begin
        cell_ok   = (in_cell[UNIT_W-1:0] == unit_id) && (int'(in_cell) >= MIN_CELL);
        word_addr = {base, held_cell};
    end
endmodule

// File: rtl/irq_req_slot.sv
module irq_req_slot #(
    parameter int CH_W   = 6,
    parameter int CELL_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CH_W-1:0]   chan_in,
    input  logic [CELL_W-1:0] cell_in,
    output logic [CH_W-1:0]   chan_q,
    output logic [CELL_W-1:0] cell_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q <= '0;
            cell_q <= '0;
        end else if (load) begin
            chan_q <= chan_in;
            cell_q <= cell_in;
        end
    end
endmodule

// File: rtl/irq_word_merge.sv
module irq_word_merge #(
    parameter int DATA_W   = 36,
    parameter int MAP_BITS = 32,
    localparam int SEL_W   = $clog2(MAP_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] rdata,
    input  logic [SEL_W-1:0]  sel,
    output logic [DATA_W-1:0] word_q
);
    logic [DATA_W-1:0] merged;

    genvar gi;
    generate
        for (gi = 0; gi < DATA_W; gi++) begin : g_bit
            if (gi < MAP_BITS) begin : g_map
                assign merged[gi] = rdata[gi] | (sel == SEL_W'(gi));
            end else begin : g_keep
                assign merged[gi] = rdata[gi];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    word_q <= '0;
        else if (load) word_q <= merged;
    end
endmodule

// File: rtl/irq_post_fsm.sv
module irq_post_fsm
    import irq_post_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_ok,
    input  logic mem_ready,
    input  logic mem_rvalid,
    input  logic cell_set_ack,
    output logic req_ready,
    output logic load_word,
    output logic mem_req,
    output logic mem_rdclr,
    output logic cell_set_req,
    output logic busy,
    output logic reject
);
    post_state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (req_valid) nxt = req_ok ? ST_RC_ISSUE : ST_REJECT;
            ST_REJECT:   nxt = ST_IDLE;
            ST_RC_ISSUE: if (mem_ready) nxt = ST_RC_WAIT;
            ST_RC_WAIT:  if (mem_rvalid) nxt = ST_WR_ISSUE;
            ST_WR_ISSUE: if (mem_ready) nxt = ST_CELL_REQ;
            ST_CELL_REQ: if (cell_set_ack) nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready    = (state == ST_IDLE);
        busy         = (state != ST_IDLE);
        reject       = (state == ST_REJECT);
        mem_req      = (state == ST_RC_ISSUE) || (state == ST_WR_ISSUE);
        mem_rdclr    = (state == ST_RC_ISSUE);
        load_word    = (state == ST_RC_WAIT) && mem_rvalid;
        cell_set_req = (state == ST_CELL_REQ);
    end

    assert_mem_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_rdclr)));

    assert_reject_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> (!reject && !mem_req && !cell_set_req));

    assert_cell_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_set_req && !cell_set_ack) |=> cell_set_req);

    assert_write_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cell_set_req) |-> $past(mem_req && mem_ready && !mem_rdclr));
endmodule

// File: rtl/irq_post_seq.sv
module irq_post_seq #(
    parameter int CELL_W   = 5,
    parameter int UNIT_W   = 2,
    parameter int BASE_W   = 13,
    parameter int CH_W     = 6,
    parameter int DATA_W   = 36,
    parameter int MAP_BITS = 32,
    parameter int MIN_CELL = 4,
    localparam int ADDR_W  = BASE_W + CELL_W,
    localparam int SEL_W   = $clog2(MAP_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [UNIT_W-1:0] unit_id,
    input  logic [BASE_W-1:0] mpx_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CH_W-1:0]   req_chan,
    input  logic [CELL_W-1:0] req_cell,
    output logic              mem_req,
    output logic              mem_rdclr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              cell_set_req,
    output logic [CELL_W-1:0] cell_set_num,
    input  logic              cell_set_ack,
    output logic              busy,
    output logic              reject
);
    logic              cell_ok;
    logic              load_word;
    logic              take;
    logic [CH_W-1:0]   chan_q;
    logic [CELL_W-1:0] cell_q;

    assign take         = req_valid && req_ready;
    assign cell_set_num = cell_q;

    irq_req_check #(.CELL_W(CELL_W), .UNIT_W(UNIT_W), .BASE_W(BASE_W), .MIN_CELL(MIN_CELL)) u_check (
        .in_cell(req_cell), .unit_id(unit_id), .base(mpx_base),
        .held_cell(cell_q), .cell_ok(cell_ok), .word_addr(mem_addr)
    );

    irq_req_slot #(.CH_W(CH_W), .CELL_W(CELL_W)) u_slot (
        .clk(clk), .rst_n(rst_n), .load(take),
        .chan_in(req_chan), .cell_in(req_cell),
        .chan_q(chan_q), .cell_q(cell_q)
    );

    irq_word_merge #(.DATA_W(DATA_W), .MAP_BITS(MAP_BITS)) u_merge (
        .clk(clk), .rst_n(rst_n), .load(load_word),
        .rdata(mem_rdata), .sel(chan_q[SEL_W-1:0]), .word_q(mem_wdata)
    );

    irq_post_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ok(cell_ok),
        .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .cell_set_ack(cell_set_ack),
        .req_ready(req_ready), .load_word(load_word), .mem_req(mem_req),
        .mem_rdclr(mem_rdclr), .cell_set_req(cell_set_req), .busy(busy), .reject(reject)
    );

    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> $stable(mem_addr));

    assert_wr_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rdclr) |-> mem_wdata[chan_q[SEL_W-1:0]]);

    assert_num_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_set_req && !cell_set_ack) |=> $stable(cell_set_num));

    assert_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || cell_set_req) |-> (busy && !req_ready));
endmodule

// File: tb/sim_irq_post_seq.sv
`timescale 1ns/1ps
module sim_irq_post_seq;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [1:0]  unit_id = 2'd2;
    logic [12:0] mpx_base = 13'h0A5C;
    logic        req_valid = 0;
    logic        req_ready;
    logic [5:0]  req_chan = '0;
    logic [4:0]  req_cell = '0;
    logic        mem_req, mem_rdclr;
    logic [17:0] mem_addr;
    logic [35:0] mem_wdata;
    logic        mem_ready = 0, mem_rvalid = 0;
    logic [35:0] mem_rdata = '0;
    logic        cell_set_req;
    logic [4:0]  cell_set_num;
    logic        cell_set_ack = 0;
    logic        busy, reject;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    irq_post_seq u0 (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic t_reset();
        chk("R1 ready", req_ready, 1);
        chk("R1 busy", busy, 0);
        chk("R1 reject", reject, 0);
        chk("R1 mem_req", mem_req, 0);
        chk("R1 cell_set_req", cell_set_req, 0);
    endtask

    task automatic t_post(input logic [5:0] ch, input logic [4:0] cl, input logic [35:0] rd,
                          input int ws, input int lat, input int ackd);
        logic [17:0] ea;
        logic [35:0] ew;
        ea = {mpx_base, cl};
        ew = rd | (36'd1 << ch[4:0]);
        req_chan = ch; req_cell = cl; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        chk("R3 rdclr req", mem_req, 1);
        chk("R3 rdclr op", mem_rdclr, 1);
        chk("R2 rd addr", mem_addr, ea);
        chk("R7 busy", busy, 1);
        for (int i = 0; i < ws; i++) begin
            @(negedge clk);
            chk("R6 held req", mem_req, 1);
            chk("R6 held addr", mem_addr, ea);
        end
        mem_ready = 1;
        @(negedge clk);
        mem_ready = 0;
        chk("R3 wait no req", mem_req, 0);
        for (int i = 0; i < lat; i++) @(negedge clk);
        mem_rvalid = 1; mem_rdata = rd;
        @(negedge clk);
        mem_rvalid = 0; mem_rdata = '0;
        chk("R5 write req", mem_req, 1);
        chk("R5 write op", mem_rdclr, 0);
        chk("R2 wr addr", mem_addr, ea);
        chk("R4 R9 wdata", mem_wdata, ew);
        chk("R5 no cell yet", cell_set_req, 0);
        for (int i = 0; i < ws; i++) begin
            @(negedge clk);
            chk("R6 held wr", mem_req, 1);
            chk("R5 cell held off", cell_set_req, 0);
        end
        mem_ready = 1;
        @(negedge clk);
        mem_ready = 0;
        chk("R5 cell req", cell_set_req, 1);
        chk("R5 cell num", cell_set_num, cl);
        chk("R5 mem idle", mem_req, 0);
        req_valid = 1; req_chan = 6'd1; req_cell = 5'd2;
        for (int i = 0; i < ackd; i++) begin
            @(negedge clk);
            chk("R10 cell held", cell_set_req, 1);
            chk("R10 num held", cell_set_num, cl);
            chk("R7 not ready", req_ready, 0);
        end
        cell_set_ack = 1;
        @(negedge clk);
        cell_set_ack = 0; req_valid = 0;
        chk("R7 idle busy", busy, 0);
        chk("R7 idle ready", req_ready, 1);
        chk("R7 cell dropped", cell_set_req, 0);
        chk("R7 offered req ignored", reject, 0);
        @(negedge clk);
    endtask

    task automatic t_reject(input logic [4:0] cl);
        req_chan = 6'd5; req_cell = cl; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        chk("R8 reject pulse", reject, 1);
        chk("R8 no mem", mem_req, 0);
        @(negedge clk);
        chk("R8 pulse ends", reject, 0);
        chk("R8 ready again", req_ready, 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R8 still no mem", mem_req, 0);
            chk("R8 no cell set", cell_set_req, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_post(6'd3, 5'd6, 36'd0, 0, 1, 0);
        t_post(6'h3F, 5'd30, 36'hF_0000_0001, 2, 3, 2);
        t_post(6'h20, 5'd10, 36'h0_0000_0001, 1, 0, 1);
        t_reject(5'd2);
        t_reject(5'd7);
        unit_id = 2'd0;
        @(negedge clk);
        t_reject(5'd0);
        t_post(6'd17, 5'd4, 36'h5_5555_5555, 0, 2, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule